// File: doc/BRIEF.md
# Register-Indirect Effective Address Generator

This block forms the memory address of one instruction operand. It reads a base pointer from a set of eight 32-bit address registers. Slot 7 of that set is the stack pointer, which is either the user or the supervisor copy. It can also take the program counter as the base. An offset may be added to the base: a sign-extended 16-bit displacement, or a sign-extended 8-bit displacement plus an index value taken from a data or address register. For the auto-step modes, the block also returns the updated pointer value, which the surrounding core writes back to the register it named.

Each request is taken on a clock edge while `req_valid` is high. One clock later the result appears on the output registers. The full 32-bit sum is kept for the write-back path. The bus address is the low 24 bits of that sum. Fetch, decode and the memory access itself belong to the surrounding core.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wb_en`, `bus_addr` and `wb_val` are 0 at the next clock edge.
- R2: Mode 0 (plain indirect): `bus_addr` is the selected register's low 24 bits, one clock after the request, and `out_valid` is 1.
- R3: Mode 1 (step after): `bus_addr` is the old register value, `wb_en` is 1 and `wb_val` is the register plus the step.
- R4: Mode 2 (step before): `wb_val` is the register minus the step, `bus_addr` equals the low 24 bits of `wb_val`, and `wb_en` is 1.
- R5: The step is taken from `size`. The codes are 0 = byte (step 1), 1 = word (step 2), and 2 or 3 = long (step 4).
- R6: When register 7 takes a byte-sized step, the step is 2.
- R7: Register 7, whether used as base or as index, reads `ssp` when `supervisor` is 1 and `usp` otherwise. Slots 0..6 come from `an_file`, with slot i at bits [32i+31:32i].
- R8: Mode 3: the address is the register plus `disp16` sign-extended to 32 bits.
- R9: Mode 4: the address is the register plus `disp8` sign-extended, plus the index. The index is address register `idx_sel` when `idx_is_addr` is 1, and data register `idx_sel` otherwise (from `dn_file`, slot i at bits [32i+31:32i]). The index is used as 32 bits when `idx_long` is 1, and as its low 16 bits sign-extended otherwise.
- R10: Mode 5 is `pc` + sign-extended `disp16`. Mode 6 is `pc` + sign-extended `disp8` + index, with the index formed as in R9.
- R11: All sums are 32-bit, with carries above bit 31 dropped. `bus_addr` is bits 23..0 of the sum, so a carry out of bit 23 does not appear on it.
- R12: A request with mode 7, or a clock with `req_valid` low, gives `out_valid` = 0 and `wb_en` = 0 on the next cycle.
- R13: `wb_en` is 1 only for modes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code (see R2..R12) |
| reg_sel | input | 3 | Base address register number |
| size | input | 2 | Operand size code |
| supervisor | input | 1 | Selects supervisor stack pointer for register 7 |
| disp16 | input | 16 | 16-bit signed displacement |
| disp8 | input | 8 | 8-bit signed displacement |
| idx_is_addr | input | 1 | Index from address (1) or data (0) register |
| idx_sel | input | 3 | Index register number |
| idx_long | input | 1 | Index used as 32 bits (1) or sign-extended word (0) |
| pc | input | 32 | Program counter |
| an_file | input | 224 | Address registers 0..6, flattened |
| usp | input | 32 | User stack pointer |
| ssp | input | 32 | Supervisor stack pointer |
| dn_file | input | 256 | Data registers 0..7, flattened |
| out_valid | output | 1 | Result valid |
| bus_addr | output | 24 | Effective bus address |
| wb_en | output | 1 | Register write-back enable |
| wb_val | output | 32 | New register value |

## Verification
The assertions check the per-cycle relations that hold without knowing the register contents. They cover the reset clearing, suppression of invalid and reserved-mode requests, write-back only in the two stepping modes, the address equalling the written value in step-before mode, and the size-dependent gap between the write-back value and the address in step-after mode, including the byte step of 2 on register 7. Correct base selection, stack pointer choice, sign extension of displacements and index, PC-relative sums and the 24-bit truncation at wrap-around all depend on the data values. Only the bench shows these, by comparing random and directed requests against its own model.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW   = 32,
  parameter int BW   = 24,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [2:0]              mode,
  input  logic [$clog2(NREG)-1:0] reg_sel,
  input  logic [1:0]              size,
  input  logic                    supervisor,
  input  logic [15:0]             disp16,
  input  logic [7:0]              disp8,
  input  logic                    idx_is_addr,
  input  logic [$clog2(NREG)-1:0] idx_sel,
  input  logic                    idx_long,
  input  logic [AW-1:0]           pc,
  input  logic [(NREG-1)*AW-1:0]  an_file,
  input  logic [AW-1:0]           usp,
  input  logic [AW-1:0]           ssp,
  input  logic [NREG*AW-1:0]      dn_file,
  output logic                    out_valid,
  output logic [BW-1:0]           bus_addr,
  output logic                    wb_en,
  output logic [AW-1:0]           wb_val
);
  localparam int RW = $clog2(NREG);
  localparam logic [RW-1:0] SP_IDX = RW'(NREG - 1);

  logic [AW-1:0] sp_now;
  assign sp_now = supervisor ? ssp : usp;

  function automatic logic [AW-1:0] read_an(input logic [RW-1:0] sel,
                                            input logic [AW-1:0] sp);
    logic [AW-1:0] v;
    v = sp;
    for (int i = 0; i < NREG - 1; i++)
      if (sel == RW'(i)) v = an_file[i*AW +: AW];
    return v;
  endfunction

  function automatic logic [AW-1:0] read_dn(input logic [RW-1:0] sel);
    logic [AW-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++)
      if (sel == RW'(i)) v = dn_file[i*AW +: AW];
    return v;
  endfunction

  logic [AW-1:0] base, idx_raw, idx_val, off16, off8, step, sum;
  logic          good, stepping;

  assign base    = read_an(reg_sel, sp_now);
  assign idx_raw = idx_is_addr ? read_an(idx_sel, sp_now) : read_dn(idx_sel);
  assign idx_val = idx_long ? idx_raw : {{(AW-16){idx_raw[15]}}, idx_raw[15:0]};
  assign off16   = {{(AW-16){disp16[15]}}, disp16};
  assign off8    = {{(AW-8){disp8[7]}}, disp8};

  always_comb begin
    case (size)
      2'd0:    step = (reg_sel == SP_IDX) ? AW'(2) : AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  always_comb begin
    case (mode)
      3'd1:    sum = base;
      3'd2:    sum = base - step;
      3'd3:    sum = base + off16;
      3'd4:    sum = base + off8 + idx_val;
      3'd5:    sum = pc + off16;
      3'd6:    sum = pc + off8 + idx_val;
      default: sum = base;
    endcase
  end

  assign good     = req_valid && (mode != 3'd7);
  assign stepping = (mode == 3'd1) || (mode == 3'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bus_addr  <= '0;
      wb_en     <= 1'b0;
      wb_val    <= '0;
    end else begin
      out_valid <= good;
      wb_en     <= good && stepping;
      if (good) begin
        bus_addr <= sum[BW-1:0];
        wb_val   <= (mode == 3'd1) ? base + step : sum;
      end
    end
  end
endmodule

module ea_gen_chk #(
  parameter int AW   = 32,
  parameter int BW   = 24,
  parameter int NREG = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [2:0]              mode,
  input logic [$clog2(NREG)-1:0] reg_sel,
  input logic [1:0]              size,
  input logic                    out_valid,
  input logic [BW-1:0]           bus_addr,
  input logic                    wb_en,
  input logic [AW-1:0]           wb_val
);
  localparam logic [$clog2(NREG)-1:0] SP_IDX = $clog2(NREG)'(NREG - 1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !wb_en && bus_addr == '0 && wb_val == '0));

  // R12
  no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || mode == 3'd7) |=> (!out_valid && !wb_en));

  // R13
  wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode != 3'd1 && mode != 3'd2) |=> !wb_en);

  // R4
  predec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd2) |=> (wb_en && out_valid && wb_val[BW-1:0] == bus_addr));

  // R5
  postinc_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd1 && size[1]) |=> (wb_en && BW'(wb_val[BW-1:0] - bus_addr) == BW'(4)));

  // R5
  postinc_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd1 && size == 2'd1) |=> (wb_en && BW'(wb_val[BW-1:0] - bus_addr) == BW'(2)));

  // R6
  postinc_spbyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd1 && size == 2'd0 && reg_sel == SP_IDX) |=> (BW'(wb_val[BW-1:0] - bus_addr) == BW'(2)));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .BW(BW), .NREG(NREG)) u_chk (.*);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [2:0]   mode = '0, reg_sel = '0, idx_sel = '0;
  logic [1:0]   size = '0;
  logic         supervisor = 1'b0, idx_is_addr = 1'b0, idx_long = 1'b0;
  logic [15:0]  disp16 = '0;
  logic [7:0]   disp8 = '0;
  logic [31:0]  pc = '0, usp = '0, ssp = '0;
  logic [223:0] an_file = '0;
  logic [255:0] dn_file = '0;
  logic         out_valid, wb_en;
  logic [23:0]  bus_addr;
  logic [31:0]  wb_val;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ea_gen dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] areg(input logic [2:0] n);
    if (n == 3'd7) return supervisor ? ssp : usp;
    return an_file[n*32 +: 32];
  endfunction

  logic [31:0] e_addr, e_wb;
  bit          e_valid, e_wb_en;

  task automatic model();
    logic [31:0] b, ix, st, d16, d8;
    b   = areg(reg_sel);
    ix  = idx_is_addr ? areg(idx_sel) : dn_file[idx_sel*32 +: 32];
    if (!idx_long) ix = {{16{ix[15]}}, ix[15:0]};
    d16 = {{16{disp16[15]}}, disp16};
    d8  = {{24{disp8[7]}}, disp8};
    st  = (size == 2'd0) ? ((reg_sel == 3'd7) ? 32'd2 : 32'd1) : (size == 2'd1) ? 32'd2 : 32'd4;
    e_valid = req_valid && mode != 3'd7;
    e_wb_en = e_valid && (mode == 3'd1 || mode == 3'd2);
    e_wb = 32'h0;
    case (mode)
      3'd1: begin e_addr = b; e_wb = b + st; end
      3'd2: begin e_addr = b - st; e_wb = b - st; end
      3'd3: e_addr = b + d16;
      3'd4: e_addr = b + d8 + ix;
      3'd5: e_addr = pc + d16;
      3'd6: e_addr = pc + d8 + ix;
      default: e_addr = b;
    endcase
  endtask

  task automatic run(input string tag);
    model();
    @(negedge clk);
    chk(out_valid == e_valid, {tag, " valid (R12)"}, 32'(out_valid), 32'(e_valid));
    chk(wb_en == e_wb_en, {tag, " wb_en (R13)"}, 32'(wb_en), 32'(e_wb_en));
    if (e_valid) chk(bus_addr == e_addr[23:0], {tag, " addr (R11)"}, 32'(bus_addr), 32'(e_addr[23:0]));
    if (e_wb_en) chk(wb_val == e_wb, {tag, " wb_val"}, wb_val, e_wb);
  endtask

  task automatic randomize_files();
    for (int i = 0; i < 7; i++) an_file[i*32 +: 32] = $urandom;
    for (int i = 0; i < 8; i++) dn_file[i*32 +: 32] = $urandom;
    usp = $urandom; ssp = $urandom; pc = $urandom;
  endtask

  task automatic req(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s);
    req_valid = 1'b1; mode = m; reg_sel = r; size = s;
  endtask

  initial begin
    void'($urandom(32'd1234));
    randomize_files();
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid == 1'b0 && wb_en == 1'b0, "R1 reset flags", {30'd0, out_valid, wb_en}, 32'd0);
    chk(bus_addr == 24'd0 && wb_val == 32'd0, "R1 reset data", {8'd0, bus_addr}, 32'd0);
    rst_n = 1'b1;

    // R2 plain indirect
    an_file[3*32 +: 32] = 32'h12AB_CDEF; req(3'd0, 3'd3, 2'd1); run("R2 plain");
    chk(bus_addr == 24'hABCDEF, "R2 addr", 32'(bus_addr), 32'h00ABCDEF);
    // R3 R5 post step, each size
    an_file[1*32 +: 32] = 32'h0000_1000;
    req(3'd1, 3'd1, 2'd0); run("R3 R5 byte");
    chk(wb_val == 32'h1001, "R5 byte step", wb_val, 32'h1001);
    req(3'd1, 3'd1, 2'd1); run("R3 R5 word");
    chk(wb_val == 32'h1002, "R5 word step", wb_val, 32'h1002);
    req(3'd1, 3'd1, 2'd3); run("R3 R5 long");
    chk(wb_val == 32'h1004 && bus_addr == 24'h1000, "R3 long", wb_val, 32'h1004);
    // R4 pre step from zero wraps
    an_file[0 +: 32] = 32'h0;
    req(3'd2, 3'd0, 2'd2); run("R4 wrap");
    chk(wb_val == 32'hFFFF_FFFC && bus_addr == 24'hFFFFFC, "R4 R11 wrap", wb_val, 32'hFFFFFFFC);
    // R6 R7 stack byte steps
    usp = 32'h0000_2000; ssp = 32'h0000_8000;
    supervisor = 1'b1; req(3'd1, 3'd7, 2'd0); run("R6 R7 super");
    chk(bus_addr == 24'h8000 && wb_val == 32'h8002, "R6 R7 ssp byte", wb_val, 32'h8002);
    supervisor = 1'b0; req(3'd2, 3'd7, 2'd0); run("R6 R7 user");
    chk(bus_addr == 24'h1FFE, "R6 R7 usp predec", 32'(bus_addr), 32'h1FFE);
    // R8 negative displacement
    an_file[2*32 +: 32] = 32'h0001_0000; disp16 = 16'h8000;
    req(3'd3, 3'd2, 2'd1); run("R8 neg");
    chk(bus_addr == 24'h008000, "R8 sext", 32'(bus_addr), 32'h8000);
    // R9 word index sign-extended
    an_file[4*32 +: 32] = 32'h0000_0100; dn_file[5*32 +: 32] = 32'h1234_FFFE;
    disp8 = 8'hFF; idx_is_addr = 1'b0; idx_sel = 3'd5; idx_long = 1'b0;
    req(3'd4, 3'd4, 2'd1); run("R9 wordidx");
    chk(bus_addr == 24'h0000FD, "R9 word index", 32'(bus_addr), 32'hFD);
    idx_long = 1'b1; run("R9 longidx");
    chk(bus_addr == 24'h3500FD, "R9 long index", 32'(bus_addr), 32'h003500FD);
    // R10 pc relative
    pc = 32'h00FF_FFF0; disp16 = 16'h0020; req(3'd5, 3'd0, 2'd1); run("R10 pc16");
    chk(bus_addr == 24'h000010, "R10 R11 carry drop", 32'(bus_addr), 32'h10);
    // R12 reserved and idle
    req(3'd7, 3'd0, 2'd1); run("R12 reserved");
    req_valid = 1'b0; mode = 3'd1; run("R12 idle");

    for (int n = 0; n < 400; n++) begin
      randomize_files();
      req_valid = ($urandom % 8) != 0;
      mode = 3'($urandom); reg_sel = 3'($urandom); size = 2'($urandom);
      supervisor = 1'($urandom); disp16 = 16'($urandom); disp8 = 8'($urandom);
      idx_is_addr = 1'($urandom); idx_sel = 3'($urandom); idx_long = 1'($urandom);
      run("rand R2 R3 R4 R7 R8 R9 R10");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); chk(1'b0, "watchdog", 32'd0, 32'd1); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule